// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a synchronous single-word request port and an asynchronous EDO DRAM. Each accepted request carries a word address, a write flag, write data and per-byte enables. The block splits the address into a row half and a column half and puts them on a shared address pin group one after the other. It then drives the row strobe, one column strobe per byte lane, the write-enable strobe and the output-enable strobe in the order the memory needs. Read data is captured from the memory's data pins and returned with a single-cycle valid pulse.

After an access the row is left open, with the row strobe held low. A following request to the same row is served as a page-mode cycle: only a new column is presented and the column strobes toggle again. A request to another row, or a pending refresh, closes the row and waits out the precharge time before any new row is opened. Refresh timing is not part of the block. It only closes the row and signals, through a grant, that the memory is idle and precharged. All memory timings are parameters counted in clock cycles.

Top module: `edo_seq`

## Requirements
- R1: Out of reset the row strobe, both column strobes, write enable and output enable are high (inactive), no data lane is driven, `rd_valid` is low and `req_ready` is high.
- R2: A request address splits into row = `req_addr[19:10]` and column = `req_addr[9:0]`. The row is on `dram_addr` when the row strobe falls, and the column is on `dram_addr` when a column strobe falls and stays stable while it is low.
- R3: `dram_cas_n[0]` serves data bits 7:0 and `dram_cas_n[1]` serves bits 15:8. `req_be[i]` = 1 enables lane i, and only the enabled lanes' column strobes fall. Column strobes fall only while the row strobe is low.
- R4: A write drives write enable low at least one cycle before the column strobe falls, keeps output enable high, and drives only the enabled lanes (`dram_dq_oe[i]`). A read keeps write enable high and holds output enable low while the column strobe is low. While the row strobe is high no lane is driven.
- R5: A read returns the memory data on enabled lanes and zero on disabled lanes, with `rd_valid` high for exactly one cycle.
- R6: A read that opens a new row returns `rd_valid` T_RCD+1+max(T_CAC, T_AA-1, T_RAC-T_RCD-1, 1) cycles after the accepting edge (5 with defaults).
- R7: A request to the open row with no refresh since is accepted with the row strobe still low (page hit). A page-hit read returns `rd_valid` 1+max(T_CAC, T_AA-1, 1) cycles after acceptance (3 with defaults).
- R8: A request to a different row closes the open row. The row strobe stays high for at least T_RP cycles before it falls again.
- R9: While `ref_req` is high no request is accepted and any open row is closed. `ref_gnt` is high only with the row strobe high, in the idle state. The first access after a refresh opens its row anew.
- R10: `req_ready` is low whenever any column strobe is low.
- R11: A column strobe falls no earlier than T_RCD+1 cycles after the row strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper half |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = low byte; at least one set |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh wants the memory |
| ref_gnt | output | 1 | Memory idle and precharged for refresh |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 2 | Per-lane drive enable for the data pads |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
Every strobe is a register loaded at the same edge as the state change. So the row strobe falls at the accepting edge, a column strobe falls T_RCD+1 edges later on a new row, or one edge later on a page hit. Read data appears after a further max(T_CAC, T_AA-1, …) edges. The bench records the cycle number at acceptance on the falling clock edge and compares the cycle in which `rd_valid` is seen against these formulas. Its memory model samples the strobes at every falling clock edge. It checks row, column, lane and write-enable order at the strobe edges, and the precharge and row-to-column gaps, by counting cycles between those edges.

// File: rtl/edo_seq_pkg.sv
// Package: shared types and helpers for the EDO DRAM sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package edo_seq_pkg;

    // Sequencer states; the row strobe is low in ROW, COLSET, CAS and OPEN.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ROW    = 3'd1,
        ST_COLSET = 3'd2,
        ST_CAS    = 3'd3,
        ST_OPEN   = 3'd4,
        ST_PRE    = 3'd5
    } edo_state_t;

    // Larger of two integers, used for derived timing.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_timer.sv
// Timer: three saturating age counters (time in state, time since the row
// strobe fell, time since a new column was presented) and the timing
// comparisons built on them. A counter value q at an edge means q+1 cycles
// have elapsed. Assumes CW is wide enough for the largest timing parameter.
module edo_timer #(
    parameter int CW    = 6,
    parameter int T_RCD = 2,
    parameter int T_RP  = 3,
    parameter int T_CP  = 2,
    parameter int T_CAC = 2,
    parameter int T_AA  = 3,
    parameter int T_RAC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ras_start,
    input  logic col_start,
    output logic rcd_done,
    output logic rp_done,
    output logic cp_ok,
    output logic cas_rd_done,
    output logic cas_wr_done
);

    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] phase_q;
    logic [CW-1:0] ras_q;
    logic [CW-1:0] col_q;

    // Cycles spent in the current state.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)   phase_q <= '0;
        else if (phase_q != SAT) phase_q <= phase_q + CW'(1);
    end

    // Cycles since the row strobe fell.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_start) ras_q <= '0;
        else if (ras_q != SAT)   ras_q <= ras_q + CW'(1);
    end

    // Cycles since the current column was put on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n || col_start) col_q <= '0;
        else if (col_q != SAT)   col_q <= col_q + CW'(1);
    end

    // Elapsed-time comparisons against the timing parameters.
    always_comb begin
        rcd_done    = (int'(phase_q) + 1) >= T_RCD;
        rp_done     = (int'(phase_q) + 1) >= T_RP;
        cp_ok       = (int'(phase_q) + 2) >= T_CP;
        cas_wr_done = (int'(phase_q) + 1) >= T_CAC;
        cas_rd_done = cas_wr_done
                    && ((int'(col_q) + 1) >= T_AA)
                    && ((int'(ras_q) + 1) >= T_RAC);
    end

endmodule

// File: rtl/edo_addr_path.sv
// Address path: latches the accepted request, keeps the open row, decides
// a page hit and drives the multiplexed address pins (row first, then
// column). Assumes accept and load_col are never high together.
module edo_addr_path #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int DW    = 16,
    parameter int LANES = 2,
    parameter int PIN_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic                   from_idle,
    input  logic                   load_col,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   req_write,
    input  logic [DW-1:0]          req_wdata,
    input  logic [LANES-1:0]       req_be,
    output logic                   hit,
    output logic                   wr_q,
    output logic [LANES-1:0]       be_q,
    output logic [DW-1:0]          wdata_q,
    output logic                   nxt_wr,
    output logic [LANES-1:0]       nxt_be,
    output logic [PIN_W-1:0]       pin_addr
);

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [PIN_W-1:0] row_pins;
    logic [PIN_W-1:0] col_pins;
    logic [PIN_W-1:0] colq_pins;

    // Split the request address and widen both halves to the pin width.
    always_comb begin
        req_row   = req_addr[ROW_W+COL_W-1:COL_W];
        req_col   = req_addr[COL_W-1:0];
        row_pins  = '0;
        col_pins  = '0;
        colq_pins = '0;
        row_pins[ROW_W-1:0]  = req_row;
        col_pins[COL_W-1:0]  = req_col;
        colq_pins[COL_W-1:0] = col_q;
    end

    // Page-hit compare and next-cycle view of the latched attributes.
    always_comb begin
        hit    = (req_row == row_q);
        nxt_wr = accept ? req_write : wr_q;
        nxt_be = accept ? req_be    : be_q;
    end

    // Latch request attributes on acceptance; the row only when opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            col_q   <= '0;
            row_q   <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            col_q   <= req_col;
            if (from_idle) row_q <= req_row;
        end
    end

    // Address pins: row on opening, column on a page hit or after tRCD.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pin_addr <= '0;
        else if (accept && from_idle) pin_addr <= row_pins;
        else if (accept)              pin_addr <= col_pins;
        else if (load_col)            pin_addr <= colq_pins;
    end

endmodule

// File: rtl/edo_lane.sv
// Byte lane: registered column strobe and pad drive enable for one lane,
// plus capture of that lane's read data (zero when the lane is disabled).
// Assumes the control inputs describe the next cycle.
module edo_lane #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cas_on,
    input  logic          drive_on,
    input  logic          lane_en,
    input  logic          capture,
    input  logic          cap_en,
    input  logic [LW-1:0] dq_in,
    output logic          cas_n,
    output logic          dq_oe,
    output logic [LW-1:0] rd_lane
);

    // Strobe and drive enable follow the next-state decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_n <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cas_n <= !(cas_on && lane_en);
            dq_oe <= drive_on && lane_en;
        end
    end

    // Read capture at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_lane <= '0;
        else if (capture) rd_lane <= cap_en ? dq_in : '0;
    end

endmodule

// File: rtl/edo_seq.sv
// EDO DRAM access sequencer top. Accepts one request at a time, opens a
// row, presents the column, runs the column strobes per byte lane and
// keeps the row open for page hits. All strobes are registers loaded from
// the next-state decode, so they change only at clock edges. Assumes
// req_be is never zero and that the refresh owner waits for ref_gnt.
module edo_seq #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int DW    = 16,
    parameter int CW    = 6,
    parameter int T_RCD = 2,
    parameter int T_RP  = 3,
    parameter int T_CP  = 2,
    parameter int T_CAC = 2,
    parameter int T_AA  = 3,
    parameter int T_RAC = 5,
    localparam int AW    = ROW_W + COL_W,
    localparam int LANES = DW / 8,
    localparam int PIN_W = edo_seq_pkg::imax(ROW_W, COL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_be,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    input  logic             ref_req,
    output logic             ref_gnt,
    output logic [PIN_W-1:0] dram_addr,
    output logic             dram_ras_n,
    output logic [LANES-1:0] dram_cas_n,
    output logic             dram_we_n,
    output logic             dram_oe_n,
    output logic [DW-1:0]    dram_dq_out,
    output logic [LANES-1:0] dram_dq_oe,
    input  logic [DW-1:0]    dram_dq_in
);

    import edo_seq_pkg::*;

    edo_state_t       state_q;
    edo_state_t       nxt;
    logic             accept;
    logic             hit;
    logic             wr_q;
    logic             nxt_wr;
    logic [LANES-1:0] be_q;
    logic [LANES-1:0] nxt_be;
    logic [DW-1:0]    wdata_q;
    logic             rcd_done;
    logic             rp_done;
    logic             cp_ok;
    logic             cas_rd_done;
    logic             cas_wr_done;
    logic             capture;
    logic             rd_valid_q;
    logic             ras_n_q;
    logic             we_n_q;
    logic             oe_n_q;

    // Handshake, refresh grant and acceptance.
    always_comb begin
        req_ready = !ref_req && ((state_q == ST_IDLE)
                  || ((state_q == ST_OPEN) && hit && cp_ok));
        accept    = req_valid && req_ready;
        ref_gnt   = (state_q == ST_IDLE) && ref_req;
    end

    // Next-state decision, including the page-hit / close choice.
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) nxt = ST_ROW;
            ST_ROW:    if (rcd_done) nxt = ST_COLSET;
            ST_COLSET: nxt = ST_CAS;
            ST_CAS:    if (wr_q ? cas_wr_done : cas_rd_done) nxt = ST_OPEN;
            ST_OPEN: begin
                if (ref_req)                nxt = ST_PRE;
                else if (accept)            nxt = ST_COLSET;
                else if (req_valid && !hit) nxt = ST_PRE;
            end
            ST_PRE:    if (rp_done) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Read data is taken on the edge that ends a read's strobe window.
    always_comb capture = (state_q == ST_CAS) && (nxt == ST_OPEN) && !wr_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Shared strobes registered from the next-state decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n_q    <= 1'b1;
            we_n_q     <= 1'b1;
            oe_n_q     <= 1'b1;
            rd_valid_q <= 1'b0;
        end else begin
            ras_n_q    <= !(nxt inside {ST_ROW, ST_COLSET, ST_CAS, ST_OPEN});
            we_n_q     <= !((nxt inside {ST_ROW, ST_COLSET, ST_CAS}) && nxt_wr);
            oe_n_q     <= !((nxt == ST_CAS) && !nxt_wr);
            rd_valid_q <= capture;
        end
    end

    edo_timer #(
        .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_CP(T_CP),
        .T_CAC(T_CAC), .T_AA(T_AA), .T_RAC(T_RAC)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (nxt != state_q),
        .ras_start  ((nxt == ST_ROW) && (state_q != ST_ROW)),
        .col_start  (nxt == ST_COLSET),
        .rcd_done   (rcd_done),
        .rp_done    (rp_done),
        .cp_ok      (cp_ok),
        .cas_rd_done(cas_rd_done),
        .cas_wr_done(cas_wr_done)
    );

    edo_addr_path #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .LANES(LANES), .PIN_W(PIN_W)
    ) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .from_idle(state_q == ST_IDLE),
        .load_col ((state_q == ST_ROW) && (nxt == ST_COLSET)),
        .req_addr (req_addr),
        .req_write(req_write),
        .req_wdata(req_wdata),
        .req_be   (req_be),
        .hit      (hit),
        .wr_q     (wr_q),
        .be_q     (be_q),
        .wdata_q  (wdata_q),
        .nxt_wr   (nxt_wr),
        .nxt_be   (nxt_be),
        .pin_addr (dram_addr)
    );

    // One strobe / drive / capture slice per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edo_lane #(.LW(8)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .cas_on  (nxt == ST_CAS),
            .drive_on((nxt inside {ST_COLSET, ST_CAS}) && nxt_wr),
            .lane_en (nxt_be[g]),
            .capture (capture),
            .cap_en  (be_q[g]),
            .dq_in   (dram_dq_in[g*8 +: 8]),
            .cas_n   (dram_cas_n[g]),
            .dq_oe   (dram_dq_oe[g]),
            .rd_lane (rd_data[g*8 +: 8])
        );
    end

    // Port assignments.
    always_comb begin
        dram_ras_n  = ras_n_q;
        dram_we_n   = we_n_q;
        dram_oe_n   = oe_n_q;
        dram_dq_out = wdata_q;
        rd_valid    = rd_valid_q;
    end

endmodule

// File: rtl/edo_seq_chk.sv
// Checker: protocol properties on the sequencer's ports, bound to edo_seq.
module edo_seq_chk #(
    parameter int LANES = 2,
    parameter int PIN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             ref_gnt,
    input logic [PIN_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic [LANES-1:0] dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic [LANES-1:0] dram_dq_oe
);

    logic cas_any;
    always_comb cas_any = (dram_cas_n != '1);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cas_any |-> !req_ready);

    assert_gnt_row_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> dram_ras_n);

    assert_cas_inside_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cas_any |-> !dram_ras_n);

    assert_we_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_any && ($past(dram_cas_n) == '1) && !dram_we_n) |-> !$past(dram_we_n));

    assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    assert_standby_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ras_n |-> (dram_dq_oe == '0));

    assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_col_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_any && ($past(dram_cas_n) != '1)) |-> $stable(dram_addr));

endmodule

bind edo_seq edo_seq_chk #(.LANES(LANES), .PIN_W(PIN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .ref_gnt   (ref_gnt),
    .dram_addr (dram_addr),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n),
    .dram_oe_n (dram_oe_n),
    .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_seq_tb_top.sv
// Bench: EDO memory model sampled on falling clock edges, directed corner
// cases and seeded random traffic, checked against bench-side expectations.
module edo_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 2, T_RP = 3, T_CP = 2, T_CAC = 2, T_AA = 3, T_RAC = 5;
    localparam int L_MISS = edo_seq_pkg::imax(edo_seq_pkg::imax(T_CAC, T_AA - 1),
                            edo_seq_pkg::imax(T_RAC - T_RCD - 1, 1));
    localparam int L_HIT  = edo_seq_pkg::imax(edo_seq_pkg::imax(T_CAC, T_AA - 1), 1);
    localparam int LAT_MISS = T_RCD + 1 + L_MISS;
    localparam int LAT_HIT  = 1 + L_HIT;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ready, rd_valid, ref_gnt;
    logic [15:0] rd_data;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_we_n, dram_oe_n;
    logic [1:0]  dram_cas_n, dram_dq_oe;
    logic [15:0] dram_dq_out;
    logic [15:0] dq_in_r = '0;

    edo_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_CP(T_CP), .T_CAC(T_CAC),
              .T_AA(T_AA), .T_RAC(T_RAC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dq_in_r));

    int n_checks = 0, n_err = 0;
    bit done = 1'b0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] mem_dram [int];
    logic [15:0] mem_ref  [int];
    int          cur_addr = 0;
    bit          cur_write = 1'b0;
    logic [1:0]  cur_be = 2'b00;
    int          open_row_b = -1;
    bit          ref_since = 1'b0;

    function automatic logic [15:0] init_word(input int a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    // Memory model and per-cycle port checks, all on the falling edge.
    logic       p_ras = 1'b1;
    logic [1:0] p_cas = 2'b11;
    int ras_rise_c = -1000, ras_fall_c = 0, row_lat = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                check(cyc - ras_rise_c >= T_RP, "R8 precharge cycles", cyc - ras_rise_c, T_RP);
                check(int'(dram_addr) == (cur_addr >> 10), "R2 row", dram_addr, cur_addr >> 10);
                row_lat = int'(dram_addr);
                ras_fall_c = cyc;
            end
            if (!p_ras && dram_ras_n) ras_rise_c = cyc;
            for (int l = 0; l < 2; l++) begin
                if (p_cas[l] && !dram_cas_n[l]) begin
                    int a;
                    logic [15:0] w;
                    a = row_lat * 1024 + int'(dram_addr);
                    check(cur_be[l], "R3 strobe only on enabled lane", l, cur_be);
                    check(int'(dram_addr) == (cur_addr & 1023), "R2 column", dram_addr, cur_addr & 1023);
                    check(cyc - ras_fall_c >= T_RCD + 1, "R11 row-to-column", cyc - ras_fall_c, T_RCD + 1);
                    w = mem_dram.exists(a) ? mem_dram[a] : init_word(a);
                    if (!dram_we_n) begin
                        check(cur_write && dram_oe_n && dram_dq_oe[l], "R4 write strobes",
                              {dram_oe_n, dram_dq_oe[l]}, 2'b11);
                        w[l*8 +: 8] = dram_dq_out[l*8 +: 8];
                        mem_dram[a] = w;
                    end else begin
                        check(!cur_write && !dram_oe_n, "R4 read strobes", dram_oe_n, 0);
                        dq_in_r[l*8 +: 8] = w[l*8 +: 8];
                    end
                end
            end
            if (dram_cas_n != 2'b11) check(!req_ready, "R10 ready low while busy", req_ready, 0);
            if (ref_gnt) check(dram_ras_n, "R9 grant with row closed", dram_ras_n, 1);
            if (dram_ras_n) check(dram_dq_oe == 2'b00, "R4 no drive in standby", dram_dq_oe, 0);
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
        end
    end

    // Issue one request and, for reads, check data and latency.
    task automatic do_req(input int addr, input bit wr, input logic [15:0] wd,
                          input logic [1:0] be);
        bit exp_hit;
        int ea, n;
        logic [15:0] cur, expd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr[19:0];
        req_wdata = wd; req_be = be;
        #1;
        n = 0;
        while (!req_ready && n < 100) begin
            @(negedge clk); #1; n++;
        end
        exp_hit = (open_row_b == (addr >> 10)) && !ref_since;
        check(dram_ras_n == !exp_hit, exp_hit ? "R7 page hit keeps row open" :
              "R8 miss reopens row", dram_ras_n, !exp_hit);
        cur_addr = addr; cur_write = wr; cur_be = be;
        cur = mem_ref.exists(addr) ? mem_ref[addr] : init_word(addr);
        for (int l = 0; l < 2; l++) begin
            if (be[l]) begin
                if (wr) cur[l*8 +: 8] = wd[l*8 +: 8];
                expd[l*8 +: 8] = cur[l*8 +: 8];
            end else expd[l*8 +: 8] = 8'h00;
        end
        if (wr) mem_ref[addr] = cur;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ea = cyc;
        open_row_b = addr >> 10;
        ref_since = 1'b0;
        if (!wr) begin
            n = 0;
            while (!rd_valid && n < 40) begin
                @(negedge clk); n++;
            end
            check(rd_valid, "R5 read returns", rd_valid, 1);
            check(cyc - ea == (exp_hit ? LAT_HIT : LAT_MISS), exp_hit ? "R7 hit latency" :
                  "R6 miss latency", cyc - ea, exp_hit ? LAT_HIT : LAT_MISS);
            check(rd_data == expd, "R5 read data with lane masking", rd_data, expd);
            @(negedge clk);
            check(!rd_valid, "R5 single-cycle valid", rd_valid, 0);
        end
    endtask

    // Ask for refresh, expect the row to close and the grant to appear.
    task automatic do_refresh();
        int n;
        @(negedge clk);
        ref_req = 1'b1;
        n = 0;
        while (!ref_gnt && n < 20) begin
            @(negedge clk); n++;
        end
        check(ref_gnt && dram_ras_n, "R9 refresh grant", {ref_gnt, dram_ras_n}, 2'b11);
        check(!req_ready, "R9 no acceptance during refresh", req_ready, 0);
        repeat (2) @(negedge clk);
        ref_req = 1'b0;
        ref_since = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && dram_oe_n,
              "R1 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1f);
        check(dram_dq_oe == 2'b00 && !rd_valid && req_ready, "R1 bus and handshake",
              {dram_dq_oe, rd_valid, req_ready}, 4'b0001);
        // Directed cases
        do_req(32'h01403, 1'b1, 16'hBEEF, 2'b11);   // R6/R8 miss write
        do_req(32'h01403, 1'b0, 16'h0000, 2'b11);   // R7 hit read
        do_req(32'h01407, 1'b1, 16'hA5C3, 2'b10);   // R3 upper byte write
        do_req(32'h01407, 1'b0, 16'h0000, 2'b01);   // R3/R5 lower byte read
        do_req(32'h01407, 1'b0, 16'h0000, 2'b10);   // R5 upper byte read
        do_req(32'hFFFFF, 1'b0, 16'h0000, 2'b11);   // R2/R8 top address, row miss
        do_req(32'h00000, 1'b0, 16'h0000, 2'b11);   // R6 row 0 miss read
        do_refresh();                               // R9
        do_req(32'h00001, 1'b0, 16'h0000, 2'b11);   // R9 same row after refresh: miss
        // Random traffic over a few rows so hits and misses mix
        for (int i = 0; i < 400; i++) begin
            int row, col;
            logic [1:0] be;
            row = int'($urandom_range(0, 3)) * 257;
            col = int'($urandom_range(0, 1023));
            be  = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 15) == 0) do_refresh();
            do_req(row * 1024 + col, 1'($urandom_range(0, 1)), 16'($urandom), be);
        end
        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired: actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule